// File: doc/BRIEF.md
# High-Speed Clock Start-Up Gate and PLL Lock Monitor

This block sits between the raw high-speed clock sources of a small microcontroller and its clock tree. The PLL output should run at 250 times a 32.768 kHz reference, which is 8.192 MHz. After oscillation is enabled, the block holds the high-speed clock output low until the PLL has produced a fixed number of settling pulses. Only then does it let the clock through, and it does so without glitches.

A frequency monitor runs alongside the gate. It counts PLL edges over each reference period and raises a lock flag while the ratio stays close to 250. A three-bit mode field chooses the PLL path, the external clock path, or neither. A separate select input decides whether the system clock comes from the high-speed path or from the reference. When the PLL path feeds the system clock, the block delivers half the PLL rate.

All state lives in the PLL clock domain. That domain has a synchronous active-low reset. The reference is brought into it through a two-flop synchronizer.

Top module: `hsclk_ctrl`

## Requirements
- R1: The mode field `mode[2:0]` selects the PLL path at 3'b010 and the external path at 3'b100. Every other value selects no high-speed source.
- R2: In PLL mode, `hs_ready` stays 0 for the first 4095 rising PLL edges at which `osc_en`=1 and `stop_req`=0 are sampled. It reads 1 after the 4096th such edge.
- R3: In PLL mode, `hs_clk` has no rising edges while `hs_ready` is 0. Once ready, `hs_clk` pulses once per PLL cycle.
- R4: Whenever a full reference period contains a PLL edge count from 244 to 256 inclusive, the lock flag reads 1 after that measurement. Whenever the count lies outside that range, the lock flag reads 0.
- R5: A single out-of-window reference period clears `lock` within a few PLL cycles of its closing reference edge. `lock` returns after the next in-window period.
- R6: Clearing `osc_en` clears `hs_ready` and `lock` on the next edge. A later enable restarts the full 4096-pulse count.
- R7: While `stop_req`=1, `hs_ready`=0 and `lock`=0, and both `hs_clk` and `sys_clk` show no rising edges.
- R8: In PLL mode with `sel_hs`=1 and the gate open, `sys_clk` toggles at half the PLL rate.
- R9: In external mode with `osc_en`=1 and `stop_req`=0, `hs_clk` follows `clk_ext` at once, with no settling count. `lock` and `hs_ready` stay 0.
- R10: Under any mode encoding other than 3'b010 or 3'b100, `hs_clk` shows no edges and `lock` stays 0.
- R11: With `sel_hs`=0, `sys_clk` carries the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL output clock; all registers run on it |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_ref | input | 1 | 32.768 kHz reference clock |
| clk_ext | input | 1 | External high-speed clock input |
| osc_en | input | 1 | Oscillation enable |
| stop_req | input | 1 | STOP request; halts the high-speed path |
| mode | input | 3 | Source encoding (010 PLL, 100 external) |
| sel_hs | input | 1 | 1 selects the high-speed path for `sys_clk` |
| hs_clk | output | 1 | Gated high-speed clock |
| sys_clk | output | 1 | System clock (half PLL, external, or reference) |
| hs_ready | output | 1 | PLL settling count complete |
| lock | output | 1 | PLL frequency within window |

## Verification
A wrong settling count shows up on `hs_ready` exactly at PLL edge 4096 after enable. The bench probes both edge 4095 and edge 4096. A bad period counter or a bad window bound shifts the lock boundary in a sweep of reference periods from 240 to 260 PLL cycles, so `lock` disagrees at 243/244 or at 256/257 within four reference periods. A gate or divider fault shows up as a wrong count of `hs_clk` or `sys_clk` edges within a few hundred cycles.

// File: rtl/hsclk_pkg.sv
// Shared constants for the high-speed clock controller.
// Assumes a three-bit source mode field.
package hsclk_pkg;
    localparam logic [2:0] MODE_PLL = 3'b010;
    localparam logic [2:0] MODE_EXT = 3'b100;
endpackage

// File: rtl/hsclk_settle.sv
// Settling counter: counts PLL cycles while run is high and reports done
// once SETTLE cycles have elapsed. Assumes run is synchronous to clk.
module hsclk_settle #(
    parameter int SETTLE = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(SETTLE + 1);
    localparam logic [W-1:0] LIMIT = W'(SETTLE);

    logic [W-1:0] cnt_q;

    // Count up to the limit while running, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIMIT);

    // R6: a dropped run clears done on the next edge
    p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !done);
    // R2: done can only rise after a running cycle
    p_done_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));
endmodule

// File: rtl/hsclk_lockdet.sv
// Lock detector: synchronizes the reference into the PLL domain, counts PLL
// cycles between reference rising edges and flags lock when the count is
// within [LO, HI]. The first edge after run rises only primes the counter.
module hsclk_lockdet #(
    parameter int RATIO = 250,
    parameter int LO    = 244,
    parameter int HI    = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_in,
    output logic lock
);
    localparam int W = $clog2(2 * RATIO);
    localparam logic [W-1:0] SAT = '1;

    logic       s1_q, s2_q, s3_q;
    logic       primed_q;
    logic [W-1:0] per_q;
    logic       ref_edge;
    logic [W:0] meas;
    logic       meas_vld;
    logic       in_win;

    assign ref_edge = s2_q & ~s3_q;
    assign meas     = {1'b0, per_q} + 1'b1;
    assign meas_vld = ref_edge & primed_q;
    assign in_win   = (meas >= (W+1)'(LO)) && (meas <= (W+1)'(HI));

    // Synchronize the reference and keep a delayed copy for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= ref_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Measure the period and update the lock flag at each reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            per_q    <= '0;
            primed_q <= 1'b0;
            lock     <= 1'b0;
        end else if (ref_edge) begin
            per_q    <= '0;
            primed_q <= 1'b1;
            if (primed_q)
                lock <= in_win;
        end else if (per_q != SAT) begin
            per_q <= per_q + 1'b1;
        end
    end

    // R5: an out-of-window measurement drops lock on the next edge
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld && (meas < (W+1)'(LO) || meas > (W+1)'(HI)) |=> !lock);
    // R4: lock only rises after a completed measurement
    p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(meas_vld));
    // R6: loss of run clears lock
    p_lock_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !lock);
endmodule

// File: rtl/hsclk_div2.sv
// Divide-by-two: toggles while enabled and parks low when disabled.
module hsclk_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic q
);
    // Toggle on each enabled edge, hold low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            q <= 1'b0;
        else
            q <= ~q;
    end

    // R8: the divider alternates on consecutive enabled edges
    p_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && $past(rst_n) |-> q != $past(q));
endmodule

// File: rtl/hsclk_ctrl.sv
// High-speed clock controller top. Decodes the mode field, gates the PLL
// clock after the settling count, monitors PLL lock against the reference
// and builds the system clock. Assumes the enables and the mode change
// only while clk_ext is low when the external path is in use.
module hsclk_ctrl
    import hsclk_pkg::*;
#(
    parameter int SETTLE  = 4096,
    parameter int RATIO   = 250,
    parameter int LOCK_LO = 244,
    parameter int LOCK_HI = 256
) (
    input  logic       clk_pll,
    input  logic       rst_n,
    input  logic       clk_ref,
    input  logic       clk_ext,
    input  logic       osc_en,
    input  logic       stop_req,
    input  logic [2:0] mode,
    input  logic       sel_hs,
    output logic       hs_clk,
    output logic       sys_clk,
    output logic       hs_ready,
    output logic       lock
);
    logic pll_sel, ext_sel, base_run, pll_run, ext_run;
    logic gate_q, div_q, hs_path;

    assign pll_sel  = (mode == MODE_PLL);
    assign ext_sel  = (mode == MODE_EXT);
    assign base_run = osc_en & ~stop_req;
    assign pll_run  = base_run & pll_sel;
    assign ext_run  = base_run & ext_sel;

    hsclk_settle #(.SETTLE(SETTLE)) u_settle (
        .clk  (clk_pll),
        .rst_n(rst_n),
        .run  (pll_run),
        .done (hs_ready)
    );

    hsclk_lockdet #(.RATIO(RATIO), .LO(LOCK_LO), .HI(LOCK_HI)) u_lock (
        .clk   (clk_pll),
        .rst_n (rst_n),
        .run   (pll_run),
        .ref_in(clk_ref),
        .lock  (lock)
    );

    // Capture the gate enable while the PLL clock is low to avoid glitches.
    always_ff @(negedge clk_pll) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= hs_ready & pll_run;
    end

    hsclk_div2 u_div (
        .clk  (clk_pll),
        .rst_n(rst_n),
        .en   (hs_ready & pll_run),
        .q    (div_q)
    );

    // Select the gated high-speed clock and the system clock source.
    always_comb begin
        if (pll_sel)
            hs_clk = clk_pll & gate_q;
        else if (ext_sel)
            hs_clk = clk_ext & ext_run;
        else
            hs_clk = 1'b0;
        hs_path = pll_sel ? div_q : hs_clk;
        sys_clk = sel_hs ? hs_path : clk_ref;
    end

    // R7: a STOP request clears readiness and lock on the next edge
    p_stop_r7: assert property (@(posedge clk_pll) disable iff (!rst_n)
        stop_req |=> !hs_ready && !lock);
    // R10: no recognized source keeps lock low
    p_other_mode_r10: assert property (@(posedge clk_pll) disable iff (!rst_n)
        !pll_sel && !ext_sel |=> !lock);
    // R9: external mode never reports PLL readiness
    p_ext_ready_r9: assert property (@(posedge clk_pll) disable iff (!rst_n)
        ext_sel |=> !hs_ready);
endmodule

// File: tb/hsclk_ctrl_tb.sv
`timescale 1ns/1ps
module hsclk_ctrl_tb;
    logic clk_pll = 1'b0, clk_ref = 1'b0, clk_ext = 1'b0;
    logic rst_n = 1'b0, osc_en = 1'b0, stop_req = 1'b0, sel_hs = 1'b0;
    logic [2:0] mode = 3'b010;
    logic hs_clk, sys_clk, hs_ready, lock;
    int total = 0, bad = 0;
    int ref_half = 500;
    int n_hs = 0, n_sys = 0, n_ref = 0;
    bit done = 1'b0;

    hsclk_ctrl u_dut (
        .clk_pll(clk_pll), .rst_n(rst_n), .clk_ref(clk_ref), .clk_ext(clk_ext),
        .osc_en(osc_en), .stop_req(stop_req), .mode(mode), .sel_hs(sel_hs),
        .hs_clk(hs_clk), .sys_clk(sys_clk), .hs_ready(hs_ready), .lock(lock)
    );

    always #2 clk_pll = ~clk_pll;
    always #5 clk_ext = ~clk_ext;
    initial begin
        #1;
        forever begin
            clk_ref = 1'b1; #(ref_half);
            clk_ref = 1'b0; #(ref_half);
        end
    end

    always @(posedge hs_clk)  n_hs++;
    always @(posedge sys_clk) n_sys++;
    always @(posedge clk_ref) n_ref++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk_pll);
        #1;
    endtask

    task automatic near(input int act, input int exp, input string tag);
        chk(act >= exp - 1 && act <= exp + 1, tag, act, exp);
    endtask

    task automatic settle_check(input string tag);
        @(negedge clk_pll);
        osc_en = 1'b1;
        cyc(4095);
        chk(hs_ready == 1'b0, {tag, " before 4096"}, hs_ready, 0);
        cyc(1);
        chk(hs_ready == 1'b1, {tag, " at 4096"}, hs_ready, 1);
    endtask

    initial begin
        int a;
        cyc(5);
        chk(hs_ready == 0 && lock == 0, "reset state", {hs_ready, lock}, 0);
        rst_n = 1'b1;
        cyc(2);

        // R3: no hs_clk edges before ready
        @(negedge clk_pll); osc_en = 1'b1;
        a = n_hs; cyc(100);
        chk(n_hs == a, "R3 gated before ready", n_hs - a, 0);
        @(negedge clk_pll); osc_en = 1'b0;
        cyc(2);

        // R2 / R1: settling count in PLL mode 010
        settle_check("R2 R1");
        cyc(4);
        a = n_hs; cyc(400);
        near(n_hs - a, 400, "R3 full rate after ready");

        // R8: halved system clock
        sel_hs = 1'b1;
        cyc(2);
        a = n_sys; cyc(400);
        near(n_sys - a, 200, "R8 half rate");

        // R4: sweep reference period 240..260 PLL cycles
        for (int n = 240; n <= 260; n++) begin
            ref_half = 2 * n;
            repeat (4) @(posedge clk_ref);
            cyc(8);
            chk(lock == ((n >= 244 && n <= 256) ? 1'b1 : 1'b0),
                $sformatf("R4 period %0d", n), lock, (n >= 244 && n <= 256));
        end
        ref_half = 500;
        repeat (3) @(posedge clk_ref);
        cyc(8);
        chk(lock == 1'b1, "R4 relock at 250", lock, 1);

        // R5: one long period drops lock, next good period restores it
        @(negedge clk_ref); #1 ref_half = 580;
        @(negedge clk_ref); #1 ref_half = 500;
        @(posedge clk_ref);
        cyc(8);
        chk(lock == 1'b0, "R5 drop after one bad period", lock, 0);
        repeat (2) @(posedge clk_ref);
        cyc(8);
        chk(lock == 1'b1, "R5 restore", lock, 1);

        // R6: disable clears, re-enable restarts full count
        @(negedge clk_pll); osc_en = 1'b0;
        cyc(1);
        chk(hs_ready == 0 && lock == 0, "R6 cleared", {hs_ready, lock}, 0);
        settle_check("R6 restart");

        // R7: STOP halts everything
        @(negedge clk_pll); stop_req = 1'b1;
        cyc(2);
        chk(hs_ready == 0 && lock == 0, "R7 flags", {hs_ready, lock}, 0);
        a = n_hs; cyc(100);
        chk(n_hs == a, "R7 hs_clk quiet", n_hs - a, 0);
        a = n_sys; cyc(100);
        chk(n_sys == a, "R7 sys_clk quiet", n_sys - a, 0);
        @(negedge clk_pll); stop_req = 1'b0; osc_en = 1'b0;

        // R9: external mode passes clk_ext immediately
        @(negedge clk_ext); mode = 3'b100; osc_en = 1'b1;
        cyc(1);
        a = n_hs; cyc(400);
        near(n_hs - a, 160, "R9 follows ext");
        chk(lock == 0 && hs_ready == 0, "R9 no lock/ready", {hs_ready, lock}, 0);
        a = n_sys; cyc(400);
        near(n_sys - a, 160, "R9 sys from ext");

        // R10 / R1: all other encodings stay dark
        for (int m = 0; m < 8; m++) begin
            if (m != 2 && m != 4) begin
                @(negedge clk_ext); mode = 3'(m);
                cyc(2);
                a = n_hs; cyc(100);
                chk(n_hs == a && lock == 0, $sformatf("R10 mode %0d", m), n_hs - a, 0);
            end
        end

        // R11: reference on sys_clk when sel_hs = 0
        mode = 3'b010; sel_hs = 1'b0;
        cyc(2);
        a = n_sys; begin int r; r = n_ref;
            cyc(1500);
            near(n_sys - a, n_ref - r, "R11 sys is ref");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #700000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule